// File: doc/BRIEF.md
# Backplane Link Bring-Up Sequencer

This block decides which operating mode a four-lane backplane Ethernet port is in while the link comes up. In the normal flow it runs auto-negotiation first, then link training, then a 40G data mode. The data mode carries FEC when FEC was negotiated. A force code, captured only when software pulses the sequencer restart, can skip negotiation and training and go straight to plain 40G data or to 40G FEC data.

Each mode change goes through a transceiver reconfiguration step. The sequencer issues a one-cycle request with a one-hot mode vector and waits for an acknowledge. It then starts the new stage: it pulses a restart to the negotiation or training engine, or it raises link-ready for a data mode. The engines report done, fail and timeout as strobes.

A negotiation timer retries a negotiation that hangs. A link-fail timer restarts the flow when a negotiated link stays down. A policy input chooses how a training failure is handled. Negotiation and training timeouts are latched as status bits.

Top module: `link_seq`

## Requirements
- R1: After reset, link-ready, both timeout status bits and both restart outputs are 0. The first reconfiguration request targets negotiation (mode bit 0) when negotiation is enabled, and training otherwise.
- R2: A `seqRestart` pulse captures `forceCode` and drops link-ready. It raises `reconfReq` in the next cycle. A change of `forceCode` without a restart has no effect on the mode.
- R3: Force code 4'b0100 selects 40G data and 4'b1100 selects 40G FEC data, with no negotiation and no training. Every other code, including 4'b0000, 4'b0101, 4'b0001 and 4'b0010, runs the normal flow.
- R4: `reconfMode` is one-hot. Bit 0 is negotiation, bit 1 is training, bit 2 is 40G data and bit 5 is 40G FEC data. Bits 3 and 4 are never set.
- R5: Each mode change drives `reconfReq` high for exactly one cycle. The new stage begins only in the cycle after the edge at which `reconfAck` is sampled. `anRestart` pulses on entry to negotiation, and `ltRestart` pulses on entry to training.
- R6: In the normal flow, `anDone` leads to training. `ltDone` leads to FEC data when `fecNeg` is 1, and to 40G data otherwise.
- R7: `linkReady` is 1 only while in a data mode after its acknowledge. It is 0 from the cycle after any restart request.
- R8: With `anTimerOff` at 0, if negotiation goes AN_LIMIT cycles without `anDone`, `anToStat` sets and `anRestart` pulses to retry. With `anTimerOff` at 1, negotiation never times out.
- R9: `anToStat` and `ltToStat` stay high until the sequencer enters the negotiation stage. On that entry both clear.
- R10: On `ltFail` or `ltTimeout` during training: with `ltFailToData` at 1 the sequencer goes to data mode. With `ltFailToData` at 0 it restarts negotiation if `anEnable` is 1, and otherwise pulses `ltRestart` and stays in training.
- R11: In a data mode reached through the normal flow, with `lfTimerOff` at 0, LF_LIMIT consecutive cycles of `pcsLinkOk` at 0 restart negotiation. `lfTimerOff` at 1 suppresses this, and forced data modes are never affected.
- R12: `ltTimeout` during training sets `ltToStat` and is then handled as a training failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seqRestart | input | 1 | Sequencer restart pulse; captures the force code |
| forceCode | input | 4 | Force-mode code |
| anEnable | input | 1 | Negotiation enabled |
| anTimerOff | input | 1 | Disables the negotiation timer |
| lfTimerOff | input | 1 | Disables the link-fail timer |
| ltFailToData | input | 1 | Training-failure policy: 1 goes to data mode |
| anDone | input | 1 | Negotiation complete strobe |
| ltDone | input | 1 | Training complete strobe |
| ltFail | input | 1 | Training failure strobe |
| ltTimeout | input | 1 | Training timeout strobe |
| fecNeg | input | 1 | FEC was negotiated |
| pcsLinkOk | input | 1 | Data-path link status |
| reconfAck | input | 1 | Reconfiguration done acknowledge |
| reconfReq | output | 1 | One-cycle reconfiguration request |
| reconfMode | output | 6 | One-hot target mode |
| linkReady | output | 1 | Link ready in data mode |
| anToStat | output | 1 | Latched negotiation timeout |
| ltToStat | output | 1 | Latched training timeout |
| anRestart | output | 1 | Restart pulse to the negotiation engine |
| ltRestart | output | 1 | Restart pulse to the training engine |

## Verification
The flow is driven through several paths. The first is a clean negotiate, train and data sequence, once without FEC and once with it. Then come a negotiation stall that must trip the retry timer, a training timeout under each failure policy, and a link drop in negotiated data mode. Force codes are exercised with and without a restart, including the unsupported codes, so forced and normal flows are told apart. Both timer disables and a slow acknowledge show which behaviour comes from the timers and which from the handshake, because the behavioural reference must agree with the outputs on every cycle.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int MODE_W = 6;
  localparam int MB_AN  = 0;
  localparam int MB_LT  = 1;
  localparam int MB_D40 = 2;
  localparam int MB_FEC = 5;

  localparam logic [3:0] FC_D40 = 4'b0100;
  localparam logic [3:0] FC_FEC = 4'b1100;

  typedef enum logic [2:0] {ST_BOOT, ST_REQ, ST_WAIT, ST_NEG, ST_TRN, ST_DATA} seqSt_e;
  typedef enum logic [1:0] {TG_AN, TG_LT, TG_D40, TG_FEC} tgt_e;

  typedef struct packed {
    logic capForce;
    logic negRun;
    logic dataRun;
    logic statClr;
    logic anToSet;
    logic ltToSet;
  } seqStrb_t;

  function automatic tgt_e startTgt(logic [3:0] code, logic anEn);
    if (code == FC_D40) return TG_D40;
    if (code == FC_FEC) return TG_FEC;
    return anEn ? TG_AN : TG_LT;
  endfunction

  function automatic logic [MODE_W-1:0] modeVec(tgt_e t);
    logic [MODE_W-1:0] v;
    v = '0;
    case (t)
      TG_AN:   v[MB_AN]  = 1'b1;
      TG_LT:   v[MB_LT]  = 1'b1;
      TG_D40:  v[MB_D40] = 1'b1;
      default: v[MB_FEC] = 1'b1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/link_seq_dp.sv
module link_seq_dp
  import lseq_pkg::*;
#(
  parameter int AN_LIMIT = 40,
  parameter int LF_LIMIT = 24
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqStrb_t strb,
  input  logic [3:0] forceCode,
  input  logic     anTimerOff,
  input  logic     lfTimerOff,
  input  logic     pcsLinkOk,
  output logic     anExpired,
  output logic     lfExpired,
  output logic     anToStat,
  output logic     ltToStat
);
  localparam int AN_W = $clog2(AN_LIMIT);
  localparam int LF_W = $clog2(LF_LIMIT);
  localparam logic [AN_W-1:0] AN_LAST = AN_W'(AN_LIMIT - 1);
  localparam logic [LF_W-1:0] LF_LAST = LF_W'(LF_LIMIT - 1);

  logic [3:0]      forceReg;
  logic [AN_W-1:0] anCnt;
  logic [LF_W-1:0] lfCnt;
  logic            negFlow;
  logic            lfCond;

  assign negFlow   = (forceReg != FC_D40) && (forceReg != FC_FEC);
  assign lfCond    = negFlow && !lfTimerOff && !pcsLinkOk;
  assign anExpired = !anTimerOff && (anCnt == AN_LAST);
  assign lfExpired = lfCond && (lfCnt == LF_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceReg <= '0;
      anCnt    <= '0;
      lfCnt    <= '0;
      anToStat <= 1'b0;
      ltToStat <= 1'b0;
    end else begin
      if (strb.capForce) forceReg <= forceCode;
      anCnt <= (strb.negRun && !anTimerOff && !anExpired) ? anCnt + 1'b1 : '0;
      lfCnt <= (strb.dataRun && lfCond && !lfExpired) ? lfCnt + 1'b1 : '0;
      if (strb.statClr) begin
        anToStat <= 1'b0;
        ltToStat <= 1'b0;
      end else begin
        if (strb.anToSet) anToStat <= 1'b1;
        if (strb.ltToSet) ltToStat <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import lseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     seqRestart,
  input  logic [3:0] forceCode,
  input  logic     anEnable,
  input  logic     ltFailToData,
  input  logic     anDone,
  input  logic     ltDone,
  input  logic     ltFail,
  input  logic     ltTimeout,
  input  logic     fecNeg,
  input  logic     reconfAck,
  input  logic     anExpired,
  input  logic     lfExpired,
  output seqStrb_t strb,
  output logic     reconfReq,
  output logic [MODE_W-1:0] reconfMode,
  output logic     linkReady,
  output logic     anRestart,
  output logic     ltRestart
);
  seqSt_e st, stNxt;
  tgt_e   tgt, tgtNxt;
  logic   anRstNxt, ltRstNxt;
  tgt_e   dataTgt;

  assign dataTgt    = fecNeg ? TG_FEC : TG_D40;
  assign reconfReq  = (st == ST_REQ);
  assign linkReady  = (st == ST_DATA);
  assign reconfMode = modeVec(tgt);

  always_comb begin
    stNxt        = st;
    tgtNxt       = tgt;
    anRstNxt     = 1'b0;
    ltRstNxt     = 1'b0;
    strb         = '0;
    strb.negRun  = (st == ST_NEG);
    strb.dataRun = (st == ST_DATA);
    if (seqRestart) begin
      strb.capForce = 1'b1;
      tgtNxt        = startTgt(forceCode, anEnable);
      stNxt         = ST_REQ;
    end else begin
      case (st)
        ST_BOOT: begin
          tgtNxt = anEnable ? TG_AN : TG_LT;
          stNxt  = ST_REQ;
        end
        ST_REQ: stNxt = ST_WAIT;
        ST_WAIT: if (reconfAck) begin
          case (tgt)
            TG_AN: begin
              stNxt        = ST_NEG;
              anRstNxt     = 1'b1;
              strb.statClr = 1'b1;
            end
            TG_LT: begin
              stNxt    = ST_TRN;
              ltRstNxt = 1'b1;
            end
            default: stNxt = ST_DATA;
          endcase
        end
        ST_NEG: begin
          if (anDone) begin
            tgtNxt = TG_LT;
            stNxt  = ST_REQ;
          end else if (anExpired) begin
            strb.anToSet = 1'b1;
            anRstNxt     = 1'b1;
          end
        end
        ST_TRN: begin
          if (ltDone) begin
            tgtNxt = dataTgt;
            stNxt  = ST_REQ;
          end else if (ltFail || ltTimeout) begin
            strb.ltToSet = ltTimeout;
            if (ltFailToData) begin
              tgtNxt = dataTgt;
              stNxt  = ST_REQ;
            end else if (anEnable) begin
              tgtNxt = TG_AN;
              stNxt  = ST_REQ;
            end else begin
              ltRstNxt = 1'b1;
            end
          end
        end
        ST_DATA: if (lfExpired) begin
          tgtNxt = anEnable ? TG_AN : TG_LT;
          stNxt  = ST_REQ;
        end
        default: stNxt = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_BOOT;
      tgt       <= TG_AN;
      anRestart <= 1'b0;
      ltRestart <= 1'b0;
    end else begin
      st        <= stNxt;
      tgt       <= tgtNxt;
      anRestart <= anRstNxt;
      ltRestart <= ltRstNxt;
    end
  end
endmodule

// File: rtl/link_seq.sv
module link_seq
  import lseq_pkg::*;
#(
  parameter int AN_LIMIT = 40,
  parameter int LF_LIMIT = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       seqRestart,
  input  logic [3:0] forceCode,
  input  logic       anEnable,
  input  logic       anTimerOff,
  input  logic       lfTimerOff,
  input  logic       ltFailToData,
  input  logic       anDone,
  input  logic       ltDone,
  input  logic       ltFail,
  input  logic       ltTimeout,
  input  logic       fecNeg,
  input  logic       pcsLinkOk,
  input  logic       reconfAck,
  output logic       reconfReq,
  output logic [5:0] reconfMode,
  output logic       linkReady,
  output logic       anToStat,
  output logic       ltToStat,
  output logic       anRestart,
  output logic       ltRestart
);
  seqStrb_t strb;
  logic     anExpired;
  logic     lfExpired;

  link_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .seqRestart(seqRestart), .forceCode(forceCode),
    .anEnable(anEnable), .ltFailToData(ltFailToData), .anDone(anDone),
    .ltDone(ltDone), .ltFail(ltFail), .ltTimeout(ltTimeout), .fecNeg(fecNeg),
    .reconfAck(reconfAck), .anExpired(anExpired), .lfExpired(lfExpired),
    .strb(strb), .reconfReq(reconfReq), .reconfMode(reconfMode),
    .linkReady(linkReady), .anRestart(anRestart), .ltRestart(ltRestart)
  );

  link_seq_dp #(.AN_LIMIT(AN_LIMIT), .LF_LIMIT(LF_LIMIT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .forceCode(forceCode),
    .anTimerOff(anTimerOff), .lfTimerOff(lfTimerOff), .pcsLinkOk(pcsLinkOk),
    .anExpired(anExpired), .lfExpired(lfExpired),
    .anToStat(anToStat), .ltToStat(ltToStat)
  );
endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       seqRestart,
  input logic       reconfAck,
  input logic       reconfReq,
  input logic [5:0] reconfMode,
  input logic       linkReady,
  input logic       anToStat,
  input logic       anRestart,
  input logic       ltRestart
);
  // R4
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(reconfMode) && !reconfMode[3] && !reconfMode[4]);

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reconfReq |=> !reconfReq);

  // R2
  restart_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqRestart |=> (reconfReq && !linkReady));

  // R7
  ready_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkReady |-> (reconfMode[2] || reconfMode[5]));

  // R7
  ready_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkReady) |-> $past(reconfAck));

  // R9
  an_to_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    anToStat |=> (anToStat || anRestart));

  // R5
  an_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    anRestart |-> reconfMode[0]);

  // R10
  lt_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    ltRestart |-> reconfMode[1]);
endmodule

bind link_seq link_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .seqRestart(seqRestart), .reconfAck(reconfAck),
  .reconfReq(reconfReq), .reconfMode(reconfMode), .linkReady(linkReady),
  .anToStat(anToStat), .anRestart(anRestart), .ltRestart(ltRestart)
);

// File: tb/link_seq_tb_top.sv
`timescale 1ns/1ps
module link_seq_tb_top;
  localparam int AN_LIM = 40;
  localparam int LF_LIM = 24;

  logic clk = 1'b0;
  logic rstN;
  logic seqRestart, anEnable, anTimerOff, lfTimerOff, ltFailToData;
  logic anDone, ltDone, ltFail, ltTimeout, fecNeg, pcsLinkOk, reconfAck;
  logic [3:0] forceCode;
  logic reconfReq, linkReady, anToStat, ltToStat, anRestart, ltRestart;
  logic [5:0] reconfMode;

  int vecCnt = 0;
  int errCnt = 0;
  int cyc = 0;
  int ackCnt = 0;
  int ackDly = 3;
  bit finished = 0;

  always #4 clk = ~clk;

  link_seq #(.AN_LIMIT(AN_LIM), .LF_LIMIT(LF_LIM)) dut_i (
    .clk(clk), .rstN(rstN), .seqRestart(seqRestart), .forceCode(forceCode),
    .anEnable(anEnable), .anTimerOff(anTimerOff), .lfTimerOff(lfTimerOff),
    .ltFailToData(ltFailToData), .anDone(anDone), .ltDone(ltDone),
    .ltFail(ltFail), .ltTimeout(ltTimeout), .fecNeg(fecNeg),
    .pcsLinkOk(pcsLinkOk), .reconfAck(reconfAck), .reconfReq(reconfReq),
    .reconfMode(reconfMode), .linkReady(linkReady), .anToStat(anToStat),
    .ltToStat(ltToStat), .anRestart(anRestart), .ltRestart(ltRestart)
  );

  // Behavioural reference: stage 0 boot, 1 request, 2 wait, 3 negotiate, 4 train, 5 data
  int mSt, mBit, mForce, mAnC, mLfC;
  bit mAnTo, mLtTo, mAnR, mLtR;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mBit = 0; mForce = 0; mAnC = 0; mLfC = 0;
      mAnTo = 0; mLtTo = 0; mAnR = 0; mLtR = 0;
    end else begin
      int nSt, nBit, nAnC, nLfC, dBit;
      bit anExp, lfCond, lfExp, nAnR, nLtR;
      anExp  = !anTimerOff && (mAnC == AN_LIM - 1);
      lfCond = (mForce != 4) && (mForce != 12) && !lfTimerOff && !pcsLinkOk;
      lfExp  = lfCond && (mLfC == LF_LIM - 1);
      nAnC = (mSt == 3 && !anTimerOff && !anExp) ? mAnC + 1 : 0;
      nLfC = (mSt == 5 && lfCond && !lfExp) ? mLfC + 1 : 0;
      dBit = fecNeg ? 5 : 2;
      nSt = mSt; nBit = mBit; nAnR = 0; nLtR = 0;
      if (seqRestart) begin
        mForce = int'(forceCode);
        nBit = (forceCode == 4'b0100) ? 2 : (forceCode == 4'b1100) ? 5 : (anEnable ? 0 : 1);
        nSt = 1;
      end else if (mSt == 0) begin
        nBit = anEnable ? 0 : 1; nSt = 1;
      end else if (mSt == 1) begin
        nSt = 2;
      end else if (mSt == 2) begin
        if (reconfAck) begin
          if (mBit == 0) begin nSt = 3; nAnR = 1; mAnTo = 0; mLtTo = 0; end
          else if (mBit == 1) begin nSt = 4; nLtR = 1; end
          else nSt = 5;
        end
      end else if (mSt == 3) begin
        if (anDone) begin nBit = 1; nSt = 1; end
        else if (anExp) begin mAnTo = 1; nAnR = 1; end
      end else if (mSt == 4) begin
        if (ltDone) begin nBit = dBit; nSt = 1; end
        else if (ltFail || ltTimeout) begin
          if (ltTimeout) mLtTo = 1;
          if (ltFailToData) begin nBit = dBit; nSt = 1; end
          else if (anEnable) begin nBit = 0; nSt = 1; end
          else nLtR = 1;
        end
      end else if (mSt == 5) begin
        if (lfExp) begin nBit = anEnable ? 0 : 1; nSt = 1; end
      end
      mSt = nSt; mBit = nBit; mAnC = nAnC; mLfC = nLfC; mAnR = nAnR; mLtR = nLtR;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!finished) begin
      cmp("R4 reconfMode", int'(reconfMode), 1 << mBit);
      cmp("R5 reconfReq", int'(reconfReq), int'(mSt == 1));
      cmp("R7 linkReady", int'(linkReady), int'(mSt == 5));
      cmp("R8 anToStat", int'(anToStat), int'(mAnTo));
      cmp("R12 ltToStat", int'(ltToStat), int'(mLtTo));
      cmp("R8 anRestart", int'(anRestart), int'(mAnR));
      cmp("R10 ltRestart", int'(ltRestart), int'(mLtR));
    end
    if (cyc > 100000 && !finished) begin
      errCnt++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  // Reconfiguration responder
  always @(negedge clk) begin
    if (!rstN) begin
      reconfAck <= 1'b0;
      ackCnt <= 0;
    end else begin
      reconfAck <= 1'b0;
      if (reconfReq) ackCnt <= ackDly;
      else if (ackCnt != 0) begin
        ackCnt <= ackCnt - 1;
        if (ackCnt == 1) reconfAck <= 1'b1;
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 seqRestart, 1 anDone, 2 ltDone, 3 ltFail, 4 ltTimeout
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: seqRestart = 1'b1;
      1: anDone = 1'b1;
      2: ltDone = 1'b1;
      3: ltFail = 1'b1;
      default: ltTimeout = 1'b1;
    endcase
    @(negedge clk);
    seqRestart = 1'b0; anDone = 1'b0; ltDone = 1'b0; ltFail = 1'b0; ltTimeout = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    seqRestart = 0; forceCode = 4'b0000; anEnable = 1; anTimerOff = 0; lfTimerOff = 0;
    ltFailToData = 0; anDone = 0; ltDone = 0; ltFail = 0; ltTimeout = 0;
    fecNeg = 0; pcsLinkOk = 1;
    waitCyc(3);
    cmp("R1 reset linkReady", int'(linkReady), 0);
    cmp("R1 reset reconfReq", int'(reconfReq), 0);
    cmp("R1 reset anToStat", int'(anToStat), 0);
    rstN = 1'b1;
    waitCyc(8);
    cmp("R1 first mode negotiation", int'(reconfMode), 1);
    // Normal flow, no FEC
    strobe(1); waitCyc(8);
    cmp("R6 training after anDone", int'(reconfMode), 2);
    strobe(2); waitCyc(8);
    cmp("R6 40G data mode", int'(reconfMode), 4);
    cmp("R7 link ready in data", int'(linkReady), 1);
    // Link-fail timer
    pcsLinkOk = 0; waitCyc(LF_LIM + 10);
    cmp("R11 link fail restarts negotiation", int'(reconfMode), 1);
    cmp("R7 ready dropped", int'(linkReady), 0);
    pcsLinkOk = 1;
    // Negotiation timeout
    waitCyc(AN_LIM + 2);
    cmp("R8 negotiation timeout latched", int'(anToStat), 1);
    strobe(1); waitCyc(8);
    cmp("R9 timeout held in training", int'(anToStat), 1);
    strobe(4);
    cmp("R12 training timeout latched", int'(ltToStat), 1);
    waitCyc(8);
    cmp("R10 failure restarts negotiation", int'(reconfMode), 1);
    cmp("R9 anToStat cleared", int'(anToStat), 0);
    cmp("R9 ltToStat cleared", int'(ltToStat), 0);
    // Failure to data with FEC
    strobe(1); waitCyc(8);
    ltFailToData = 1; fecNeg = 1;
    strobe(3); waitCyc(8);
    cmp("R10 failure to FEC data", int'(reconfMode), 32);
    cmp("R6 FEC data ready", int'(linkReady), 1);
    // Retrain path with negotiation off
    ltFailToData = 0; anEnable = 0;
    strobe(0);
    cmp("R2 request after restart", int'(reconfReq), 1);
    cmp("R7 ready low after restart", int'(linkReady), 0);
    waitCyc(8);
    cmp("R3 no force starts training", int'(reconfMode), 2);
    strobe(3);
    cmp("R10 retrain pulse", int'(ltRestart), 1);
    cmp("R10 stays in training", int'(reconfMode), 2);
    // Forced modes
    forceCode = 4'b0100; strobe(0); waitCyc(8);
    cmp("R3 forced 40G data", int'(reconfMode), 4);
    cmp("R3 forced ready", int'(linkReady), 1);
    pcsLinkOk = 0; waitCyc(LF_LIM + 10);
    cmp("R11 forced mode ignores link fail", int'(linkReady), 1);
    forceCode = 4'b1100; waitCyc(4);
    cmp("R2 force change without restart", int'(reconfMode), 4);
    strobe(0); waitCyc(8);
    cmp("R3 forced FEC data", int'(reconfMode), 32);
    pcsLinkOk = 1;
    anEnable = 1; forceCode = 4'b0001; strobe(0); waitCyc(8);
    cmp("R3 unsupported code runs normal flow", int'(reconfMode), 1);
    forceCode = 4'b0010; strobe(0); waitCyc(8);
    cmp("R3 second unsupported code", int'(reconfMode), 1);
    // Timer disables
    anTimerOff = 1; waitCyc(2 * AN_LIM);
    cmp("R8 timer off no timeout", int'(anToStat), 0);
    cmp("R8 still negotiating", int'(reconfMode), 1);
    anTimerOff = 0;
    strobe(1); waitCyc(8); strobe(2); waitCyc(8);
    lfTimerOff = 1; pcsLinkOk = 0; waitCyc(2 * LF_LIM);
    cmp("R11 lf timer off keeps link", int'(linkReady), 1);
    pcsLinkOk = 1; lfTimerOff = 0;
    // Slow acknowledge
    ackDly = 10; forceCode = 4'b0101; strobe(0); waitCyc(6);
    cmp("R5 waits for ack", int'(linkReady), 0);
    cmp("R5 no restart before ack", int'(anRestart), 0);
    waitCyc(10);
    cmp("R5 negotiation after ack", int'(reconfMode), 1);
    waitCyc(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule